// File: doc/BRIEF.md
# Channel Request Intake Queue

The block takes one channel request per clock from client logic. Each request names a channel and carries a six-bit supplemental idle adjustment. The channel identifier goes into an internal queue, which a downstream channelized consumer drains through a valid/ready pop port. A pacing input limits the drain to one pop every N cycles, which models a slow consumer clock.

The single flow-control output, `req_ready`, reports whether the queue occupancy is still at or below a fixed limit. The queue is deeper than that limit, so requests that arrive after ready falls are still captured. A request is dropped only when the queue is completely full, and the drop raises an error pulse.

Beside the queue, the block holds one saturating idle accumulator per channel. A request with a non-zero adjustment adds its value to the accumulator of the named channel, whether or not the queue accepts the request. A read port shows any accumulator at all times, and a read-and-clear strobe resets the selected accumulator to zero.

Top module: `chreq_intake`

## Requirements
- R1: `req_ready` is 0 while `rst_n` is low and becomes 1 at the first clock edge after reset is released; `pop_valid` is 0 while the queue is empty.
- R2: `req_ready` is 0 whenever the queue holds more than THRESH (default 4) entries. It is 1 again in the first cycle in which occupancy is THRESH or fewer, with no hysteresis.
- R3: A request (`req_valid`=1) that arrives while the queue holds DEPTH (default 8) entries is dropped, and the contents of the queue stay unchanged. `ovf_err` is then 1 for exactly the following cycle.
- R4: Accepted channel IDs leave on `pop_chan` in arrival order. An entry is removed at a clock edge where `pop_valid` and `pop_ready` are both 1.
- R5: With `pace` = P, after a pop `pop_valid` stays 0 for P-1 cycles. A value of P of 0 or 1 allows a pop on every cycle.
- R6: When `req_valid`=1 and `req_adj` is non-zero, the value of `req_adj` (0..63) is added to accumulator `req_chan`. The new value shows on `rc_value` one cycle later.
- R7: An adjustment of 0, or a cycle with `req_valid`=0, leaves every accumulator unchanged.
- R8: Accumulators are 12 bits wide and saturate at 4095.
- R9: When the same cycle holds a read-and-clear and an adding request for the same channel, the clear is applied first. The accumulator then equals `req_adj`.
- R10: `rc_value` always shows accumulator `rc_chan` without delay. When `rc_valid`=1, that accumulator becomes 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_ready | output | 1 | Occupancy at or below the limit |
| req_valid | input | 1 | Request strobe |
| req_chan | input | 3 | Requested channel |
| req_adj | input | 6 | Idle adjustment amount |
| pop_valid | output | 1 | Queue entry available under pacing |
| pop_ready | input | 1 | Consumer takes the entry |
| pop_chan | output | 3 | Channel at the head of the queue |
| pace | input | 8 | Minimum cycles between pops |
| rc_valid | input | 1 | Read-and-clear strobe |
| rc_chan | input | 3 | Accumulator selected for reading |
| rc_value | output | 12 | Value of the selected accumulator |
| ovf_err | output | 1 | Pulse marking a dropped request |

## Verification
Inputs are driven on the falling edge, and every result is sampled on a later falling edge. `req_ready`, `pop_valid` and `ovf_err` are due one rising edge after the push or pop that changes them. `rc_value` is combinational, so a read is checked in the same half-cycle in which `rc_chan` is set, and an add or clear is checked one edge later. In the pacing sweep, `pop_valid` is compared on every cycle against a pop schedule of period max(P,1) that the bench computes itself.

// File: rtl/cri_pkg.sv
package cri_pkg;
  // Saturating sum of two unsigned values capped at lim.
  function automatic int unsigned sat_add(int unsigned a, int unsigned b, int unsigned lim);
    int unsigned s;
    s = a + b;
    return (s > lim) ? lim : s;
  endfunction

  // Wait cycles that follow a pop for a given pace setting.
  function automatic int unsigned gap_load(int unsigned p);
    return (p > 1) ? p - 1 : 0;
  endfunction
endpackage

// File: rtl/cri_fifo.sv
module cri_fifo #(
  parameter int DW    = 3,
  parameter int DEPTH = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push_req,
  input  logic [DW-1:0]                  push_data,
  input  logic                           pop_fire,
  output logic [DW-1:0]                  head,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           full,
  output logic                           empty,
  output logic                           ovf_q
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push_req && !full;
  assign head    = mem[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      ovf_q <= push_req && full;
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_fire) rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  p_ovf_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full) |=> ovf_q);
  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_fire) |=> full);
  p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_req && !pop_fire) |=> $stable(count));
  p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop_fire);
endmodule

// File: rtl/cri_pacer.sv
module cri_pacer #(
  parameter int PACEW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PACEW-1:0] pace,
  input  logic             pop_fire,
  output logic             pace_ok
);
  import cri_pkg::*;
  logic [PACEW-1:0] gap;

  assign pace_ok = (gap == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) gap <= '0;
    else if (pop_fire) gap <= PACEW'(gap_load(32'(pace)));
    else if (gap != '0) gap <= gap - 1'b1;
  end

  p_gap_after_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && pace > PACEW'(1)) |=> !pace_ok);
  p_open_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && pace <= PACEW'(1)) |=> pace_ok);
endmodule

// File: rtl/cri_sic_bank.sv
module cri_sic_bank #(
  parameter int IDW  = 3,
  parameter int ADJW = 6,
  parameter int ACCW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            add_valid,
  input  logic [IDW-1:0]  add_chan,
  input  logic [ADJW-1:0] add_amt,
  input  logic            rc_valid,
  input  logic [IDW-1:0]  rc_chan,
  output logic [ACCW-1:0] rc_value
);
  import cri_pkg::*;
  localparam int NCH = 1 << IDW;
  localparam int unsigned ACC_MAX = (1 << ACCW) - 1;

  logic [ACCW-1:0] acc_q [NCH];
  logic [NCH-1:0]  add_hit, clr_hit;

  assign rc_value = acc_q[rc_chan];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [ACCW-1:0] base;
    assign add_hit[c] = add_valid && (add_chan == IDW'(c)) && (add_amt != '0);
    assign clr_hit[c] = rc_valid && (rc_chan == IDW'(c));
    assign base       = clr_hit[c] ? '0 : acc_q[c];

    always_ff @(posedge clk) begin
      if (!rst_n) acc_q[c] <= '0;
      else if (add_hit[c]) acc_q[c] <= ACCW'(sat_add(32'(base), 32'(add_amt), ACC_MAX));
      else acc_q[c] <= base;
    end

    p_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!add_hit[c] && !clr_hit[c]) |=> $stable(acc_q[c]));
    p_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (add_hit[c] && !clr_hit[c]) |=> acc_q[c] >= $past(acc_q[c]));
    p_clear_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (add_hit[c] && clr_hit[c]) |=> acc_q[c] == ACCW'($past(add_amt)));
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[c] && !add_hit[c]) |=> acc_q[c] == '0);
  end
endmodule

// File: rtl/chreq_intake.sv
module chreq_intake #(
  parameter int IDW    = 3,
  parameter int ADJW   = 6,
  parameter int ACCW   = 12,
  parameter int DEPTH  = 8,
  parameter int THRESH = 4,
  parameter int PACEW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             req_ready,
  input  logic             req_valid,
  input  logic [IDW-1:0]   req_chan,
  input  logic [ADJW-1:0]  req_adj,
  output logic             pop_valid,
  input  logic             pop_ready,
  output logic [IDW-1:0]   pop_chan,
  input  logic [PACEW-1:0] pace,
  input  logic             rc_valid,
  input  logic [IDW-1:0]   rc_chan,
  output logic [ACCW-1:0]  rc_value,
  output logic             ovf_err
);
  localparam int CW = $clog2(DEPTH+1);

  logic          live;
  logic [CW-1:0] q_count;
  logic          q_full, q_empty, pace_ok, pop_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) live <= 1'b0;
    else live <= 1'b1;
  end

  assign pop_valid = !q_empty && pace_ok;
  assign pop_fire  = pop_valid && pop_ready;
  assign req_ready = live && (q_count <= CW'(THRESH));

  cri_fifo #(.DW(IDW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_req(req_valid), .push_data(req_chan),
    .pop_fire(pop_fire), .head(pop_chan), .count(q_count),
    .full(q_full), .empty(q_empty), .ovf_q(ovf_err)
  );

  cri_pacer #(.PACEW(PACEW)) u_pacer (
    .clk(clk), .rst_n(rst_n), .pace(pace), .pop_fire(pop_fire), .pace_ok(pace_ok)
  );

  cri_sic_bank #(.IDW(IDW), .ADJW(ADJW), .ACCW(ACCW)) u_sic (
    .clk(clk), .rst_n(rst_n), .add_valid(req_valid), .add_chan(req_chan),
    .add_amt(req_adj), .rc_valid(rc_valid), .rc_chan(rc_chan), .rc_value(rc_value)
  );

  p_ready_above_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count > CW'(THRESH)) |-> !req_ready);
  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (live && q_count == '0) |-> req_ready);
  p_empty_no_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> !pop_valid);
endmodule

// File: tb/test_chreq_intake.sv
module test_chreq_intake;
  logic       clk = 0, rst_n = 0;
  logic       req_ready, req_valid = 0, pop_valid, pop_ready = 0, ovf_err, rc_valid = 0;
  logic [2:0] req_chan = 0, pop_chan, rc_chan = 0;
  logic [5:0] req_adj = 0;
  logic [7:0] pace = 1;
  logic [11:0] rc_value;

  int errors = 0, checks = 0;
  int model [8];
  bit done = 0;

  always #4 clk = ~clk;

  chreq_intake i_chreq_intake (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_valid(req_valid),
    .req_chan(req_chan), .req_adj(req_adj), .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_chan(pop_chan), .pace(pace), .rc_valid(rc_valid), .rc_chan(rc_chan),
    .rc_value(rc_value), .ovf_err(ovf_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int bench_sat(int a, int b);
    return (a + b > 4095) ? 4095 : a + b;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 0;
    // R1: reset state
    tick(); tick();
    check("R1 ready in reset", req_ready, 0);
    check("R1 pop_valid in reset", pop_valid, 0);
    rst_n = 1;
    tick();
    check("R1 ready after reset", req_ready, 1);
    check("R1 empty pop_valid", pop_valid, 0);

    // R2 / R3: fill with no drain
    for (int n = 1; n <= 8; n++) begin
      req_valid = 1; req_chan = 3'(n - 1); req_adj = 0;
      tick();
      check("R2 ready vs occupancy", req_ready, (n <= 4) ? 1 : 0);
    end
    req_chan = 3'd5;
    tick();
    req_valid = 0;
    check("R3 overflow pulse", ovf_err, 1);
    tick();
    check("R3 overflow one cycle", ovf_err, 0);

    // R4: drain in order, ready comes back at THRESH
    pop_ready = 1;
    for (int i = 0; i < 8; i++) begin
      check("R4 pop_valid", pop_valid, 1);
      check("R4 order", pop_chan, i);
      tick();
      check("R2 ready on drain", req_ready, (7 - i <= 4) ? 1 : 0);
    end
    check("R3 dropped entry absent", pop_valid, 0);

    // R5: pacing sweep
    for (int p = 0; p <= 5; p++) begin
      int step;
      step = (p <= 1) ? 1 : p;
      pop_ready = 0; pace = 8'(p);
      for (int k = 0; k < 3; k++) begin
        req_valid = 1; req_chan = 3'(k + 2); req_adj = 0;
        tick();
      end
      req_valid = 0;
      for (int w = 0; w < 6; w++) tick();
      pop_ready = 1;
      for (int t = 0; t < 3 * step + 2; t++) begin
        check("R5 pacing", pop_valid, ((t % step == 0) && (t / step < 3)) ? 1 : 0);
        tick();
      end
    end
    pace = 1;

    // R6 / R7: add to every channel, plus zero adjustments
    for (int c = 0; c < 8; c++) begin
      req_valid = 1; req_chan = 3'(c); req_adj = 6'((c * 9 + 5) % 64);
      model[c] = bench_sat(model[c], (c * 9 + 5) % 64);
      tick();
    end
    req_chan = 3'd1; req_adj = 0;
    tick();
    req_valid = 0; req_chan = 3'd4; req_adj = 6'd33;
    tick();
    for (int c = 0; c < 8; c++) begin
      rc_chan = 3'(c); #1;
      check((c == 1 || c == 4) ? "R7 no change" : "R6 accumulate", rc_value, model[c]);
    end

    // R10: read-and-clear each channel
    for (int c = 0; c < 8; c++) begin
      rc_valid = 1; rc_chan = 3'(c); #1;
      check("R10 read", rc_value, model[c]);
      model[c] = 0;
      tick();
    end
    rc_valid = 0;
    for (int c = 0; c < 8; c++) begin
      rc_chan = 3'(c); #1;
      check("R10 cleared", rc_value, 0);
    end

    // R8: saturation
    for (int k = 0; k < 70; k++) begin
      req_valid = 1; req_chan = 3'd3; req_adj = 6'd63;
      model[3] = bench_sat(model[3], 63);
      tick();
    end
    req_valid = 0;
    rc_chan = 3'd3; #1;
    check("R8 saturate", rc_value, 4095);
    check("R8 model", model[3], 4095);

    // R9: clear then add
    req_valid = 1; req_chan = 3'd2; req_adj = 6'd10;
    tick();
    req_adj = 6'd5; rc_valid = 1; rc_chan = 3'd2; #1;
    check("R9 value before", rc_value, 10);
    tick();
    req_valid = 0; rc_valid = 0; #1;
    check("R9 clear then add", rc_value, 5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule